// File: doc/BRIEF.md
# Two-Layer Opacity Mixer with Key Color

This block merges two 8-bit pixel streams, a lower (background) layer and an upper (overlay) layer, into a single 8-bit pixel for a video DAC. Each layer's red, green and blue fields are scaled by that layer's 4-bit opacity weight. The two scaled fields are then added, and the sum is clamped so that a bright overlay on a bright background reaches full intensity instead of wrapping around to a dark value.

A programmable key color gives the overlay transparent areas. Any overlay pixel equal to the key is dropped from the mix, and the background is then scaled by a separate weight. The mixed pixel leaves through one register stage. The horizontal sync, vertical sync and blanking flags pass through a matching register, so they stay aligned with the pixel data. Video timing and frame-buffer fetch are done elsewhere. The block only sees one pixel pair per clock.

Top module: `layer_mixer`

## Requirements
- R1: A pixel word holds red in bits [7:5], green in bits [4:2] and blue in bits [1:0]. The output word uses the same positions, and each field is mixed on its own.
- R2: A field value c with weight a contributes floor(c*a/8). Weight 8 passes c unchanged, and weight 0 contributes nothing.
- R3: When the two contributions to a field add to more than that field's maximum (7 for red and green, 3 for blue), the output field is all ones.
- R4: Any weight input above 8 acts exactly as 8.
- R5: When the overlay pixel differs from the key color in any bit, the background uses weight `wt_bot_open` and the overlay uses weight `wt_top_open`.
- R6: When the overlay pixel equals the key color in all 8 bits, the background uses weight `wt_bot_keyed` and the overlay contributes nothing, whatever `wt_top_open` holds.
- R7: The mixed pixel appears on `pix_out` one clock after its inputs are sampled. `hsync_out`, `vsync_out` and `blank_out` are the corresponding inputs delayed by that same one clock.
- R8: While `rst_n` is low, `pix_out`, `hsync_out` and `vsync_out` are 0 and `blank_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset of the output register |
| pix_bot | input | 8 | Background layer pixel |
| pix_top | input | 8 | Overlay layer pixel |
| key_color | input | 8 | Overlay value treated as transparent |
| wt_bot_open | input | 4 | Background weight where the overlay is not keyed |
| wt_top_open | input | 4 | Overlay weight where the overlay is not keyed |
| wt_bot_keyed | input | 4 | Background weight where the overlay is keyed |
| hsync_in | input | 1 | Horizontal sync aligned with the input pixels |
| vsync_in | input | 1 | Vertical sync aligned with the input pixels |
| blank_in | input | 1 | Blanking flag aligned with the input pixels |
| pix_out | output | 8 | Mixed pixel, registered |
| hsync_out | output | 1 | Horizontal sync delayed to match pix_out |
| vsync_out | output | 1 | Vertical sync delayed to match pix_out |
| blank_out | output | 1 | Blanking flag delayed to match pix_out |

## Verification
The only state is the single output register, so a fault in the key compare, the weight clamp or the saturating add shows on `pix_out` exactly one clock after the pixel pair that exposes it. Such a fault does not persist past the next pixel. Sweeping every background and overlay pair under the sample weights, and every weight triple under a few chosen pixel pairs, exposes each wrong selection within one cycle of its cause. A sync or blank flag misaligned by a cycle shows up as soon as the bench toggles those inputs pixel by pixel.

// File: rtl/mix_pkg.sv
package mix_pkg;

    // Opacity weights: 4 bits, with unity opacity at 1 << MIX_WT_FRAC.
    localparam int MIX_WT_W    = 4;
    localparam int MIX_WT_FRAC = 3;
    localparam int MIX_WT_ONE  = 1 << MIX_WT_FRAC;

    typedef logic [MIX_WT_W-1:0] mix_wt_t;

    // Weights actually applied to the two layers for one pixel.
    typedef struct packed {
        mix_wt_t bot;
        mix_wt_t top;
    } mix_wt_pair_t;

endpackage

// File: rtl/mix_wt_select.sv
module mix_wt_select
    import mix_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_top,
    input  logic [PIX_W-1:0] key_color,
    input  mix_wt_t          wt_bot_open,
    input  mix_wt_t          wt_top_open,
    input  mix_wt_t          wt_bot_keyed,
    output logic             keyed,
    output mix_wt_pair_t     wt_sel
);

    localparam mix_wt_t WT_ONE = mix_wt_t'(MIX_WT_ONE);

    // Saturate any weight above unity down to unity.
    function automatic mix_wt_t clamp_wt(input mix_wt_t w);
        return (w > WT_ONE) ? WT_ONE : w;
    endfunction

    // Equality comparator on the full overlay word.
    assign keyed = (pix_top == key_color);

    // Weight multiplexers steered by the comparator.
    always_comb begin
        if (keyed) begin
            wt_sel.bot = clamp_wt(wt_bot_keyed);
            wt_sel.top = '0;
        end else begin
            wt_sel.bot = clamp_wt(wt_bot_open);
            wt_sel.top = clamp_wt(wt_top_open);
        end
    end

endmodule

// File: rtl/mix_scale.sv
module mix_scale
    import mix_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] comp,
    input  mix_wt_t      wt,
    output logic [W-1:0] scaled
);

    localparam int PW = W + MIX_WT_W;

    logic [PW-1:0] prod;

    // Weight is at most unity, so the shifted product fits back into W bits.
    assign prod   = PW'(comp) * PW'(wt);
    assign scaled = W'(prod >> MIX_WT_FRAC);

endmodule

// File: rtl/mix_sat_add.sv
module mix_sat_add #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W:0] sum;

    assign sum = {1'b0, a} + {1'b0, b};
    // The carry is spread over every bit, so an overflow pins the field at full scale.
    assign y   = sum[W-1:0] | {W{sum[W]}};

endmodule

// File: rtl/layer_mixer.sv
module layer_mixer
    import mix_pkg::*;
#(
    parameter int RED_W   = 3,
    parameter int GREEN_W = 3,
    parameter int BLUE_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [RED_W+GREEN_W+BLUE_W-1:0]   pix_bot,
    input  logic [RED_W+GREEN_W+BLUE_W-1:0]   pix_top,
    input  logic [RED_W+GREEN_W+BLUE_W-1:0]   key_color,
    input  logic [MIX_WT_W-1:0]               wt_bot_open,
    input  logic [MIX_WT_W-1:0]               wt_top_open,
    input  logic [MIX_WT_W-1:0]               wt_bot_keyed,
    input  logic                              hsync_in,
    input  logic                              vsync_in,
    input  logic                              blank_in,
    output logic [RED_W+GREEN_W+BLUE_W-1:0]   pix_out,
    output logic                              hsync_out,
    output logic                              vsync_out,
    output logic                              blank_out
);

    localparam int PIX_W  = RED_W + GREEN_W + BLUE_W;
    localparam int N_COMP = 3;
    localparam mix_wt_t WT_ONE = mix_wt_t'(MIX_WT_ONE);

    logic              keyed;
    mix_wt_pair_t      wt_sel;
    logic [PIX_W-1:0]  pix_mix;

    mix_wt_select #(.PIX_W(PIX_W)) u_sel (
        .pix_top      (pix_top),
        .key_color    (key_color),
        .wt_bot_open  (wt_bot_open),
        .wt_top_open  (wt_top_open),
        .wt_bot_keyed (wt_bot_keyed),
        .keyed        (keyed),
        .wt_sel       (wt_sel)
    );

    // Component lanes: index 0 is blue (LSBs), 1 green, 2 red (MSBs).
    for (genvar gi = 0; gi < N_COMP; gi++) begin : g_lane
        localparam int CW  = (gi == 0) ? BLUE_W : (gi == 1) ? GREEN_W : RED_W;
        localparam int LSB = (gi == 0) ? 0 : (gi == 1) ? BLUE_W : BLUE_W + GREEN_W;

        logic [CW-1:0] c_bot, c_top, s_bot, s_top, c_mix;

        assign c_bot = pix_bot[LSB +: CW];
        assign c_top = pix_top[LSB +: CW];

        mix_scale #(.W(CW)) u_scale_bot (.comp(c_bot), .wt(wt_sel.bot), .scaled(s_bot));
        mix_scale #(.W(CW)) u_scale_top (.comp(c_top), .wt(wt_sel.top), .scaled(s_top));
        mix_sat_add #(.W(CW)) u_add (.a(s_bot), .b(s_top), .y(c_mix));

        assign pix_mix[LSB +: CW] = c_mix;

        // A unity-bounded weight never grows a field.
        assert_scale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (s_bot <= c_bot) && (s_top <= c_top));

        // A saturating sum never drops below either term.
        assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (c_mix >= s_bot) && (c_mix >= s_top));
    end

    // Output pipeline register, with the sync flags held in step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_out   <= '0;
            hsync_out <= 1'b0;
            vsync_out <= 1'b0;
            blank_out <= 1'b1;
        end else begin
            pix_out   <= pix_mix;
            hsync_out <= hsync_in;
            vsync_out <= vsync_in;
            blank_out <= blank_in;
        end
    end

    assert_wt_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_sel.bot <= WT_ONE) && (wt_sel.top <= WT_ONE));

    assert_key_drops_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        keyed |-> (wt_sel.top == '0));

    assert_key_full_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_top == key_color) && (wt_bot_keyed >= WT_ONE)) |=> (pix_out == $past(pix_bot)));

    assert_zero_weights_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_top != key_color) && (wt_bot_open == '0) && (wt_top_open == '0)) |=> (pix_out == '0));

endmodule

// File: tb/layer_mixer_tb.sv
module layer_mixer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_bot = '0, pix_top = '0, key_color = '0;
    logic [3:0] wt_bot_open = '0, wt_top_open = '0, wt_bot_keyed = '0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, blank_in = 1'b0;
    logic [7:0] pix_out;
    logic       hsync_out, vsync_out, blank_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [7:0] prev_exp = '0;
    localparam int WATCHDOG = 190000;

    always #5 clk = ~clk;

    layer_mixer dut_i (
        .clk(clk), .rst_n(rst_n),
        .pix_bot(pix_bot), .pix_top(pix_top), .key_color(key_color),
        .wt_bot_open(wt_bot_open), .wt_top_open(wt_top_open), .wt_bot_keyed(wt_bot_keyed),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .blank_in(blank_in),
        .pix_out(pix_out), .hsync_out(hsync_out), .vsync_out(vsync_out), .blank_out(blank_out)
    );

    function automatic int clampw(input int w);
        return (w > 8) ? 8 : w;
    endfunction

    // Arithmetic model taken from the requirements.
    function automatic logic [7:0] model(input int b, input int t, input int k,
                                         input int wbo, input int wto, input int wbk);
        int wb, wt, r, g, bl;
        wb = (t == k) ? clampw(wbk) : clampw(wbo);
        wt = (t == k) ? 0 : clampw(wto);
        r  = ((b >> 5) & 7) * wb / 8 + ((t >> 5) & 7) * wt / 8;
        g  = ((b >> 2) & 7) * wb / 8 + ((t >> 2) & 7) * wt / 8;
        bl = (b & 3) * wb / 8 + (t & 3) * wt / 8;
        if (r > 7) r = 7;
        if (g > 7) g = 7;
        if (bl > 3) bl = 3;
        return 8'((r << 5) | (g << 2) | bl);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one pixel pair, confirm the old output holds until the edge, then check the result.
    task automatic step(input string tag, input int b, input int t, input int k,
                        input int wbo, input int wto, input int wbk, input int syn);
        logic [7:0] e;
        @(negedge clk);
        pix_bot = 8'(b); pix_top = 8'(t); key_color = 8'(k);
        wt_bot_open = 4'(wbo); wt_top_open = 4'(wto); wt_bot_keyed = 4'(wbk);
        hsync_in = syn[0]; vsync_in = syn[1]; blank_in = syn[2];
        e = model(b, t, k, wbo, wto, wbk);
        #1 check("R7 hold", pix_out, prev_exp);
        @(posedge clk);
        #2;
        check(tag, pix_out, e);
        check("R7 sync", {5'b0, blank_out, vsync_out, hsync_out}, 8'(syn & 7));
        prev_exp = e;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R8 pix", pix_out, 8'h00);
        check("R8 flags", {5'b0, blank_out, vsync_out, hsync_out}, 8'h04);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: field isolation at unity weight with a zero-weight overlay
        step("R1 red",   8'hE0, 8'h00, 8'h55, 8, 0, 0, 1);
        step("R1 green", 8'h1C, 8'h00, 8'h55, 8, 0, 0, 2);
        step("R1 blue",  8'h03, 8'h00, 8'h55, 8, 0, 0, 4);
        // R2: 7*5/8 truncates to 4 in red
        step("R2 trunc", 8'hE0, 8'h00, 8'h55, 5, 0, 0, 0);
        // R3: 4+4 overflows red
        step("R3 sat",   8'h80, 8'h80, 8'h00, 8, 8, 0, 3);
        // R6: keyed overlay dropped despite full weight
        step("R6 keyed", 8'h49, 8'hFF, 8'hFF, 0, 8, 8, 5);

        // Full pair sweep with the sample setting (key FF, weights 5/3/8)
        for (int b = 0; b < 256; b++) begin
            for (int t = 0; t < 256; t++) begin
                step((t == 255) ? "R6 sweep" : "R5 sweep", b, t, 255, 5, 3, 8, (b + t) & 7);
            end
        end

        // Weight sweep including values above unity
        for (int wbo = 0; wbo < 16; wbo++) begin
            for (int wto = 0; wto < 16; wto++) begin
                for (int wbk = 0; wbk < 16; wbk++) begin
                    step("R4 sat",   8'hFF, 8'hFF, 8'h00, wbo, wto, wbk, wbo & 7);
                    step("R6 wts",   8'hB6, 8'h24, 8'h24, wbo, wto, wbk, wto & 7);
                    step("R2 wts",   8'h6D, 8'h92, 8'h00, wbo, wto, wbk, wbk & 7);
                end
            end
        end

        // R8: reset taken mid-stream
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async pix", pix_out, 8'h00);
        check("R8 async flags", {5'b0, blank_out, vsync_out, hsync_out}, 8'h04);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule